// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Sequencer

This block is a hardware master that loads an SRAM-based FPGA through a passive serial link. It drives three lines into the target: an active-low configuration-reset line, a serial clock, and a serial data bit. It watches two lines coming back: an active-low status line and a configuration-complete flag. When `start_i` is pulsed, the block first runs the reset handshake with the target. It then takes configuration bytes from a valid/ready stream and shifts them out one bit at a time. After the last byte it checks the completion flag and sends a burst of trailing clocks. At the end it reports either success or an error code.

The serial clock comes from the system clock through a divider that can be set at run time. Each bit goes through three phases: clock low, data setup, and clock high. Each phase lasts `clk_div_i + 1` system cycles. The reset hold time, the settle time and the status-release timeout are cycle-count parameters. By default they are derived from the system clock frequency, giving 2 µs, 2 µs and 100 ms.

The state machine has seven states:
- IDLE: waits for start.
- HOLD: configuration reset held active.
- SETTLE: reset released, fixed wait.
- WAITREL: waits for the target's status line to be released.
- DATA: streams and serialises the bytes.
- CHKDONE: samples the completion flag once.
- TRAIL: sends the trailing pulses.

The transitions are:
- start: IDLE→HOLD.
- hold expiry with status low: HOLD→SETTLE.
- hold expiry with status high: HOLD→IDLE with error 1.
- settle expiry: SETTLE→WAITREL.
- status high: WAITREL→DATA.
- timeout: WAITREL→IDLE with error 2.
- all bytes sent: DATA→CHKDONE.
- abort: DATA→IDLE with error 4.
- flag high: CHKDONE→TRAIL.
- flag low: CHKDONE→IDLE with error 3.
- last pulse done: TRAIL→IDLE with success.

Top module: `ps_cfg_master`

## Requirements
- R1: While reset is active, and in IDLE, the configuration-reset output is high, the serial clock is low, and `busy_o`, `s_ready_o`, `ok_o` are 0 with `err_o` = 0.
- R2: A start pulse in IDLE drives the configuration-reset output low for exactly HOLD_CYC cycles. The serial clock never rises while that output is low.
- R3: If the status input is high in the last HOLD cycle, the run ends with `err_o` = 1. The configuration-reset output returns high and no serial clock edge is produced.
- R4: After release and SETTLE_CYC cycles, the block waits for the status input to go high. If it stays low for WAIT_CYC cycles, the run ends with `err_o` = 2, which is HOLD_CYC+SETTLE_CYC+WAIT_CYC busy cycles in total.
- R5: Each byte is sent as exactly 8 bits, bit 0 first. Data changes only while the clock is low and is stable at each rising clock edge.
- R6: Every clock-high interval lasts exactly `clk_div_i + 1` system cycles.
- R7: `s_ready_o` is high only in DATA, with the shifter empty and bytes still owed, and never while the clock is high. With no valid byte, the clock stays low. Exactly `byte_count_i` bytes are accepted.
- R8: If the completion input is low after the last byte, the run ends with `err_o` = 3 and no trailing pulses.
- R9: With the completion input high, exactly 12 trailing clock pulses follow, then `ok_o` = 1 with `err_o` = 0. A zero byte count gives only those 12 pulses.
- R10: `abort_i` in DATA ends the run at once with `err_o` = 4, the clock low and the configuration-reset output high. An abort in any other state has no effect.
- R11: The results are cleared when a run starts and held after it ends. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a configuration run (accepted in IDLE) |
| abort_i | input | 1 | Abort request (acted on in DATA only) |
| byte_count_i | input | CNT_W | Number of bytes in the bitstream |
| clk_div_i | input | DIV_W | Serial clock phase length minus one, in system cycles |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted when high together with valid |
| tgt_reset_n_o | output | 1 | Active-low configuration reset to the target |
| tgt_clk_o | output | 1 | Serial configuration clock |
| tgt_dat_o | output | 1 | Serial configuration data |
| tgt_stat_n_i | input | 1 | Target status, active low |
| tgt_done_i | input | 1 | Target configuration-complete flag |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 3 | Last error: 0 none, 1 status not asserted, 2 release timeout, 3 completion low, 4 aborted |

## Verification
The bench builds the block with HOLD_CYC = 6, SETTLE_CYC = 3, WAIT_CYC = 40, CNT_W = 8 and DIV_W = 4. With these values the release timeout fires 49 cycles after start, so the exact busy duration of the timeout path can be counted. They also keep each whole configuration run to a few hundred cycles. Divider settings 0 and 2 cover both the single-cycle phase case and a stretched phase. A gapped stream exercises the clock stall between bytes.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SETTLE,
        ST_WAITREL,
        ST_DATA,
        ST_CHKDONE,
        ST_TRAIL
    } cfg_state_t;

    typedef enum logic [1:0] {
        PH_LOW,
        PH_SETUP,
        PH_HIGH
    } bit_phase_t;

    localparam logic [2:0] ERR_NONE   = 3'd0;
    localparam logic [2:0] ERR_NOSTAT = 3'd1;
    localparam logic [2:0] ERR_TMO    = 3'd2;
    localparam logic [2:0] ERR_NODONE = 3'd3;
    localparam logic [2:0] ERR_ABORT  = 3'd4;

endpackage

// File: rtl/ps_cfg_tick.sv
module ps_cfg_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R6

endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift
    import ps_cfg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              tick_i,
    output logic              empty_o,
    output logic              clk_o,
    output logic              dat_o
);

    localparam int BC_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sreg_q;
    logic [BC_W-1:0]   bits_q;
    bit_phase_t        ph_q;

    assign empty_o = (bits_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sreg_q <= '0;
            bits_q <= '0;
            ph_q   <= PH_LOW;
            clk_o  <= 1'b0;
            dat_o  <= 1'b0;
        end else if (load_i) begin
            sreg_q <= byte_i;
            bits_q <= BC_W'(BYTE_W);
            ph_q   <= PH_LOW;
            clk_o  <= 1'b0;
        end else if (tick_i && !empty_o) begin
            unique case (ph_q)
                PH_LOW: begin
                    dat_o <= sreg_q[0];
                    ph_q  <= PH_SETUP;
                end
                PH_SETUP: begin
                    clk_o <= 1'b1;
                    ph_q  <= PH_HIGH;
                end
                PH_HIGH: begin
                    clk_o  <= 1'b0;
                    sreg_q <= sreg_q >> 1;
                    bits_q <= bits_q - 1'b1;
                    ph_q   <= PH_LOW;
                end
                default: ph_q <= PH_LOW;
            endcase
        end
    end

    AST_SH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !clk_o); // R7
    AST_SH_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> empty_o); // R7

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int CLK_HZ       = 125_000_000,
    parameter int HOLD_CYC     = CLK_HZ / 500_000,
    parameter int SETTLE_CYC   = CLK_HZ / 500_000,
    parameter int WAIT_CYC     = CLK_HZ / 10,
    parameter int TRAIL_PULSES = 12,
    parameter int CNT_W        = 16,
    parameter int DIV_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             tgt_reset_n_o,
    output logic             tgt_clk_o,
    output logic             tgt_dat_o,
    input  logic             tgt_stat_n_i,
    input  logic             tgt_done_i,
    output logic             busy_o,
    output logic             ok_o,
    output logic [2:0]       err_o
);

    localparam int TMAX = (WAIT_CYC > HOLD_CYC) ?
                          ((WAIT_CYC > SETTLE_CYC) ? WAIT_CYC : SETTLE_CYC) :
                          ((HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int TCW  = $clog2(TRAIL_PULSES + 1);

    cfg_state_t       state_q, state_d;
    logic [TW-1:0]    tmr_q;
    logic [CNT_W-1:0] sent_q;
    logic [TCW-1:0]   tcnt_q;
    logic             tclk_q;
    logic             tmr_clr, fail, fin_ok;
    logic [2:0]       fin_err;
    logic             tick, tick_en, hs, sh_clr;
    logic             sh_empty, sh_clk, sh_dat;

    assign hs      = s_valid_i && s_ready_o;
    assign tick_en = (state_q == ST_DATA && !sh_empty) || state_q == ST_TRAIL;
    assign sh_clr  = !(state_q == ST_DATA || state_q == ST_CHKDONE ||
                       state_q == ST_TRAIL);

    ps_cfg_tick #(.DIV_W(DIV_W)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (tick_en),
        .div_i (clk_div_i),
        .tick_o(tick)
    );

    ps_cfg_shift #(.BYTE_W(8)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (sh_clr),
        .load_i (hs),
        .byte_i (s_data_i),
        .tick_i (tick),
        .empty_o(sh_empty),
        .clk_o  (sh_clk),
        .dat_o  (sh_dat)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        tmr_clr = 1'b0;
        fail    = 1'b0;
        fin_ok  = 1'b0;
        fin_err = ERR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_HOLD;
                    tmr_clr = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_q == TW'(HOLD_CYC - 1)) begin
                    tmr_clr = 1'b1;
                    if (tgt_stat_n_i) begin
                        fail    = 1'b1;
                        fin_err = ERR_NOSTAT;
                    end else begin
                        state_d = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_q == TW'(SETTLE_CYC - 1)) begin
                    state_d = ST_WAITREL;
                    tmr_clr = 1'b1;
                end
            end
            ST_WAITREL: begin
                if (tgt_stat_n_i) begin
                    state_d = ST_DATA;
                end else if (tmr_q == TW'(WAIT_CYC - 1)) begin
                    fail    = 1'b1;
                    fin_err = ERR_TMO;
                end
            end
            ST_DATA: begin
                if (abort_i) begin
                    fail    = 1'b1;
                    fin_err = ERR_ABORT;
                end else if (sent_q == byte_count_i && sh_empty) begin
                    state_d = ST_CHKDONE;
                end
            end
            ST_CHKDONE: begin
                if (tgt_done_i) begin
                    state_d = ST_TRAIL;
                end else begin
                    fail    = 1'b1;
                    fin_err = ERR_NODONE;
                end
            end
            ST_TRAIL: begin
                if (tick && tclk_q && tcnt_q == TCW'(TRAIL_PULSES - 1)) begin
                    state_d = ST_IDLE;
                    fin_ok  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fail) begin
            state_d = ST_IDLE;
        end
    end

    // State and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            sent_q  <= '0;
            tcnt_q  <= '0;
            tclk_q  <= 1'b0;
            ok_o    <= 1'b0;
            err_o   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            tmr_q   <= (tmr_clr || state_q == ST_IDLE) ? '0 : tmr_q + 1'b1;
            if (state_q == ST_IDLE && start_i) begin
                sent_q <= '0;
                tcnt_q <= '0;
                tclk_q <= 1'b0;
                ok_o   <= 1'b0;
                err_o  <= ERR_NONE;
            end
            if (hs) begin
                sent_q <= sent_q + 1'b1;
            end
            if (state_q == ST_TRAIL && tick) begin
                tclk_q <= !tclk_q;
                if (tclk_q) begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
            if (fail) begin
                err_o <= fin_err;
            end
            if (fin_ok) begin
                ok_o <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o        = (state_q != ST_IDLE);
        tgt_reset_n_o = (state_q != ST_HOLD);
        tgt_clk_o     = (state_q == ST_DATA && sh_clk) ||
                        (state_q == ST_TRAIL && tclk_q);
        tgt_dat_o     = sh_dat;
        s_ready_o     = (state_q == ST_DATA) && sh_empty &&
                        (sent_q != byte_count_i);
    end

    AST_NO_CLK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_reset_n_o |-> !tgt_clk_o); // R2
    AST_DAT_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_clk_o) |-> $stable(tgt_dat_o)); // R5
    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !tgt_clk_o); // R7
    AST_HOLD_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) == ST_HOLD) |-> !$past(tgt_stat_n_i)); // R3
    AST_OK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> err_o == ERR_NONE); // R9
    AST_BUSY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!ok_o && err_o == ERR_NONE)); // R11

endmodule

// File: tb/ps_cfg_master_tb_top.sv
module ps_cfg_master_tb_top;

    localparam int HOLD   = 6;
    localparam int SETTLE = 3;
    localparam int WAITC  = 40;
    localparam int CNT_W  = 8;
    localparam int DIV_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             abort_i = 1'b0;
    logic [CNT_W-1:0] byte_count_i = '0;
    logic [DIV_W-1:0] clk_div_i = '0;
    logic [7:0]       s_data_i = '0;
    logic             s_valid_i = 1'b0;
    logic             s_ready_o;
    logic             tgt_reset_n_o, tgt_clk_o, tgt_dat_o;
    logic             tgt_stat_n_i = 1'b1;
    logic             tgt_done_i = 1'b1;
    logic             busy_o, ok_o;
    logic [2:0]       err_o;

    always #4 clk = !clk;

    ps_cfg_master #(
        .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE), .WAIT_CYC(WAITC),
        .TRAIL_PULSES(12), .CNT_W(CNT_W), .DIV_W(DIV_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .byte_count_i(byte_count_i), .clk_div_i(clk_div_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
        .tgt_reset_n_o(tgt_reset_n_o), .tgt_clk_o(tgt_clk_o), .tgt_dat_o(tgt_dat_o),
        .tgt_stat_n_i(tgt_stat_n_i), .tgt_done_i(tgt_done_i),
        .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
    );

    int   checks = 0, bad = 0;
    bit   finished = 0;
    logic [7:0] mem [0:7];
    int   n_bytes = 0, idx = 0, cyc = 0;
    bit   gap_mode = 0;
    bit   stat_stuck = 0, never_rel = 0;
    int   relc = 0;
    int   rst_low = 0, busy_cnt = 0, hi_run = 0, hi_min = 0, hi_max = 0;
    int   bad_ready = 0, rise = 0;
    logic cap [0:127];

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream source and handshake count
    always @(posedge clk) if (s_valid_i && s_ready_o) idx++;
    always @(negedge clk) begin
        cyc++;
        s_valid_i = (idx < n_bytes) && (!gap_mode || (cyc % 5) < 2);
        s_data_i  = (idx < 8) ? mem[idx] : 8'h00;
    end

    // target model and monitors
    always @(negedge clk) begin
        if (!tgt_reset_n_o) begin
            relc = 0;
            tgt_stat_n_i = stat_stuck;
        end else if (!never_rel && relc >= 2) begin
            tgt_stat_n_i = 1'b1;
        end else begin
            relc++;
        end
        if (!tgt_reset_n_o) rst_low++;
        if (busy_o) busy_cnt++;
        if (s_ready_o && tgt_clk_o) bad_ready++;
        if (tgt_clk_o) hi_run++;
        else if (hi_run > 0) begin
            if (hi_min == 0 || hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
    end
    always @(posedge tgt_clk_o) begin
        if (rise < 128) cap[rise] = tgt_dat_o;
        rise++;
    end

    task automatic setup(input int n, input bit gaps, input int div);
        @(negedge clk);
        n_bytes = 0; idx = 0; gap_mode = gaps;
        for (int k = 0; k < 8; k++) mem[k] = 8'((k * 8'h5B) ^ 8'hA6 ^ (n << 4));
        byte_count_i = CNT_W'(n);
        clk_div_i = DIV_W'(div);
        rst_low = 0; busy_cnt = 0; hi_run = 0; hi_min = 0; hi_max = 0;
        bad_ready = 0; rise = 0;
        n_bytes = n;
    endtask

    task automatic run();
        int g;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        g = 0;
        while (busy_o && g < 5000) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    function automatic int bit_errs(input int n);
        int e = 0;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++)
                if (cap[8*k+b] !== mem[k][b]) e++;
        return e;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(tgt_reset_n_o && !tgt_clk_o, "R1 lines in reset", {tgt_reset_n_o, tgt_clk_o}, 2);
        chk(!busy_o && !s_ready_o && !ok_o && err_o == 0, "R1 status in reset",
            {busy_o, s_ready_o, ok_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_normal();
        stat_stuck = 0; never_rel = 0; tgt_done_i = 1;
        setup(3, 0, 0);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; abort_i = 1'b1;   // abort outside DATA
        @(negedge clk); abort_i = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        chk(rst_low == HOLD, "R2 reset pulse length", rst_low, HOLD);
        chk(ok_o && err_o == 0, "R9 success", {ok_o, err_o}, 8);
        chk(rise == 3*8 + 12, "R9 rising edge count", rise, 36);
        chk(bit_errs(3) == 0, "R5 bit order", bit_errs(3), 0);
        chk(hi_min == 1 && hi_max == 1, "R6 high length div0", hi_max, 1);
        chk(ok_o, "R10 abort outside DATA ignored", ok_o, 1);
        repeat (4) @(negedge clk);
        chk(ok_o && !busy_o, "R11 result held", {ok_o, busy_o}, 2);
    endtask

    task automatic t_gaps();
        stat_stuck = 0; never_rel = 0; tgt_done_i = 1;
        setup(4, 1, 2);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (rise < 10) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // start while busy
        while (busy_o) @(negedge clk);
        @(negedge clk);
        chk(ok_o && err_o == 0, "R11 start while busy ignored", err_o, 0);
        chk(idx == 4, "R7 bytes accepted", idx, 4);
        chk(bad_ready == 0, "R7 ready with clock high", bad_ready, 0);
        chk(bit_errs(4) == 0 && rise == 44, "R5 gapped stream bits", rise, 44);
        chk(hi_min == 3 && hi_max == 3, "R6 high length div2", hi_max, 3);
    endtask

    task automatic t_nostat();
        stat_stuck = 1; never_rel = 0;
        setup(2, 0, 0);
        run();
        chk(err_o == 1 && !ok_o, "R3 status not asserted", err_o, 1);
        chk(rise == 0 && tgt_reset_n_o && rst_low == HOLD, "R3 no clocks, reset released", rise, 0);
        stat_stuck = 0;
    endtask

    task automatic t_timeout();
        never_rel = 1;
        setup(2, 0, 0);
        run();
        chk(err_o == 2, "R4 release timeout code", err_o, 2);
        chk(busy_cnt == HOLD + SETTLE + WAITC, "R4 timeout duration", busy_cnt, HOLD + SETTLE + WAITC);
        never_rel = 0;
    endtask

    task automatic t_nodone();
        tgt_done_i = 0;
        setup(2, 0, 1);
        run();
        chk(err_o == 3 && !ok_o, "R8 completion low", err_o, 3);
        chk(rise == 16, "R8 no trailing pulses", rise, 16);
        tgt_done_i = 1;
    endtask

    task automatic t_abort();
        setup(4, 0, 0);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (rise < 5) @(negedge clk);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        chk(err_o == 4 && !busy_o, "R10 abort code", err_o, 4);
        chk(!tgt_clk_o && tgt_reset_n_o, "R10 lines after abort", {tgt_clk_o, tgt_reset_n_o}, 1);
        repeat (20) @(negedge clk);
        chk(rise < 32 && err_o == 4, "R10 transfer stopped", rise, 5);
    endtask

    task automatic t_empty();
        setup(0, 0, 0);
        run();
        chk(ok_o && rise == 12, "R9 zero bytes trailing only", rise, 12);
        chk(!s_ready_o && idx == 0, "R7 nothing requested", idx, 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_gaps();
        t_nostat();
        t_timeout();
        t_nodone();
        t_abort();
        t_empty();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule